// File: doc/BRIEF.md
# Programmable Edge Delay Generator

This block moves selected edges of a PWM gate command later by a programmable number of fast-clock periods. It is used where a rectifier gate must switch a little after the command it follows, and the right amount of lag is found at run time. The command is sampled by a fast clock into a shift register. Each stage of the register is one delay element of one clock period. A multiplexer addressed by a delay code picks one stage. That stage is then combined with the undelayed command, so that only the rising edge, only the falling edge, or both edges are moved.

The delay code and the edge mode are taken in only while the command is low and the whole delay line holds zeros. A pulse that has already started, or an old pulse still moving down the line, therefore always finishes with the settings it started with. The output passes through one register. Every delay given below is counted on top of that single cycle of fixed latency. The PWM command is a level signal sampled on every clock, not a stream of data, so there is no handshake on any pin.

Top module: `edge_delay_gen`

## Requirements
- R1: While reset is asserted and after it is released, the delay line is cleared, `gate_out` is low, and the captured code and mode are 0 and symmetric.
- R2: With code 0 in symmetric mode, `gate_out` equals `pwm_in` as sampled one clock earlier. This is the fixed one-cycle latency and no added delay.
- R3: In symmetric mode (mode 2'b00) with code k, `gate_out` one clock after edge t equals `pwm_in` sampled at edge t-k. Both edges are therefore moved by k cycles.
- R4: In rising-only mode (mode 2'b01), `gate_out` becomes the AND of the current `pwm_in` and the sample from k edges earlier. The rise lags by k extra cycles and the fall has only the fixed latency.
- R5: In falling-only mode (mode 2'b10), `gate_out` becomes the OR of the current `pwm_in` and the sample from k edges earlier. The rise has only the fixed latency and the fall lags by k extra cycles.
- R6: Mode 2'b11 behaves exactly like symmetric mode.
- R7: `dly_code` and `edge_mode` are captured only at edges where `pwm_in` is low and all delay stages are low. At all other edges the previous settings are kept.
- R8: In rising-only mode, a pulse of k cycles or fewer produces no output pulse at all.
- R9: The line has 2^CODE_W-1 stages, so the all-ones code gives the largest delay of 2^CODE_W-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; one period is one delay element |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Undelayed gate command |
| dly_code | input | CODE_W | Requested delay in elements |
| edge_mode | input | 2 | 00/11 both edges, 01 rising only, 10 falling only |
| gate_out | output | 1 | Delayed gate command |

## Verification
The two functions that can fall in the same clock are the capture of new settings and the selection of a tap for the output. They collide when a new code is presented on the very edge at which the line first becomes idle. The collision also occurs when the code changes while a pulse, or its delayed tail, is still in the line. The bench changes the code and mode in the middle of pulses and through gaps that are shorter and longer than the line depth. A behavioural model keeps a sample history and applies the idle-capture rule, and every clock the output is compared against that model. A design that takes a new code too early will cut a tail short or bring an old pulse back, and the comparison catches this.

// File: rtl/edge_delay_pkg.sv
package edge_delay_pkg;

  typedef enum logic [1:0] {
    EM_BOTH     = 2'b00,
    EM_RISE     = 2'b01,
    EM_FALL     = 2'b10,
    EM_BOTH_ALT = 2'b11
  } edge_mode_e;

  // Joins the undelayed command with the selected tap for the chosen mode
  function automatic logic edge_join(edge_mode_e m, logic now_v, logic tap_v);
    logic r;
    case (m)
      EM_RISE: r = now_v & tap_v;
      EM_FALL: r = now_v | tap_v;
      default: r = tap_v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/edge_dly_line.sv
module edge_dly_line #(
  parameter int DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] stages,
  output logic             idle
);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stages[0] <= 1'b0;
          else        stages[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stages[g] <= 1'b0;
          else        stages[g] <= stages[g-1];
        end
      end
    end
  endgenerate

  assign idle = ~|stages;

endmodule

// File: rtl/edge_dly_tapsel.sv
module edge_dly_tapsel #(
  parameter int CODE_W = 3,
  parameter int DEPTH  = 7
) (
  input  logic              now_v,
  input  logic [DEPTH-1:0]  stages,
  input  logic [CODE_W-1:0] code,
  output logic              tap
);

  always_comb begin
    tap = now_v;
    for (int i = 0; i < DEPTH; i++) begin
      if (code == CODE_W'(i + 1)) tap = stages[i];
    end
  end

endmodule

// File: rtl/edge_dly_ctl.sv
module edge_dly_ctl #(
  parameter int CODE_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwm_in,
  input  logic                      line_idle,
  input  logic [CODE_W-1:0]         code_in,
  input  logic [1:0]                mode_in,
  output logic [CODE_W-1:0]         code_q,
  output edge_delay_pkg::edge_mode_e mode_q
);
  import edge_delay_pkg::*;

  logic arm;
  assign arm = !pwm_in && line_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= EM_BOTH;
    end else if (arm) begin
      code_q <= code_in;
      mode_q <= edge_mode_e'(mode_in);
    end
  end

  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_in || !line_idle) |=> ($stable(code_q) && $stable(mode_q)));

endmodule

// File: rtl/edge_dly_join.sv
module edge_dly_join (
  input  logic                       clk,
  input  logic                       rst_n,
  input  edge_delay_pkg::edge_mode_e mode_q,
  input  logic                       now_v,
  input  logic                       tap,
  output logic                       gate_out
);
  import edge_delay_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_out <= 1'b0;
    else        gate_out <= edge_join(mode_q, now_v, tap);
  end

  // R4
  rise_fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == EM_RISE && !now_v) |=> !gate_out);

  // R5
  fall_rise_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == EM_FALL && now_v) |=> gate_out);

endmodule

// File: rtl/edge_delay_gen.sv
module edge_delay_gen #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [CODE_W-1:0] dly_code,
  input  logic [1:0]        edge_mode,
  output logic              gate_out
);
  import edge_delay_pkg::*;

  localparam int DEPTH = (1 << CODE_W) - 1;

  logic [DEPTH-1:0]  stages;
  logic              line_idle;
  logic [CODE_W-1:0] code_q;
  edge_mode_e        mode_q;
  logic              tap;

  edge_dly_line #(.DEPTH(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .din(pwm_in),
    .stages(stages), .idle(line_idle)
  );

  edge_dly_ctl #(.CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .line_idle(line_idle),
    .code_in(dly_code), .mode_in(edge_mode),
    .code_q(code_q), .mode_q(mode_q)
  );

  edge_dly_tapsel #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_sel (
    .now_v(pwm_in), .stages(stages), .code(code_q), .tap(tap)
  );

  edge_dly_join u_join (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
    .now_v(pwm_in), .tap(tap), .gate_out(gate_out)
  );

  // R2
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0 && (mode_q == EM_BOTH || mode_q == EM_BOTH_ALT))
      |=> (gate_out == $past(pwm_in)));

endmodule

// File: tb/sim_edge_delay_gen.sv
module sim_edge_delay_gen;
  localparam int CODE_W = 3;
  localparam int DEPTH  = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pwm_in = 1'b0;
  logic [CODE_W-1:0] dly_code = '0;
  logic [1:0]        edge_mode = 2'b00;
  logic              gate_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  edge_delay_gen #(.CODE_W(CODE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dly_code(dly_code),
    .edge_mode(edge_mode), .gate_out(gate_out)
  );

  // behavioural reference: history of samples, held settings
  int hist[DEPTH];
  int m_code = 0;
  int m_mode = 0;
  int exp_out = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] = 0;
      m_code = 0; m_mode = 0; exp_out = 0;
    end else begin
      int now_v, tap_v, idle_v;
      now_v = pwm_in ? 1 : 0;
      tap_v = (m_code == 0) ? now_v : hist[m_code - 1];
      if (m_mode == 1)      exp_out = now_v & tap_v;
      else if (m_mode == 2) exp_out = now_v | tap_v;
      else                  exp_out = tap_v;
      idle_v = 1;
      for (int i = 0; i < DEPTH; i++) if (hist[i] != 0) idle_v = 0;
      if (now_v == 0 && idle_v == 1) begin
        m_code = int'(dly_code);
        m_mode = int'(edge_mode);
      end
      for (int i = DEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = now_v;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if ((gate_out ? 1 : 0) != exp_out) begin
        bad++;
        $display("FAIL %s: gate_out=%0d expected=%0d at %0t", tag, gate_out, exp_out, $time);
      end
    end
  end

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk); pwm_in = 1'b1;
    idle_cycles(hi - 1);
    @(negedge clk); pwm_in = 1'b0;
    idle_cycles(lo - 1);
  endtask

  task automatic setup(int code, int mode, string t);
    @(negedge clk);
    tag = t;
    dly_code = CODE_W'(code);
    edge_mode = 2'(mode);
    idle_cycles(12);
  endtask

  initial begin
    idle_cycles(3);
    // R1: output low under reset
    total++;
    if (gate_out !== 1'b0) begin
      bad++; $display("FAIL R1: gate_out=%0b expected=0 in reset", gate_out);
    end
    @(negedge clk); rst_n = 1'b1;
    idle_cycles(4);

    setup(0, 0, "R2");
    pulse(1, 10); pulse(3, 10); pulse(6, 12);

    setup(3, 0, "R3");
    pulse(1, 12); pulse(2, 12); pulse(5, 14);

    setup(7, 0, "R9");
    pulse(2, 15); pulse(9, 16);

    setup(2, 1, "R4");
    pulse(4, 12); pulse(6, 12);
    tag = "R8";
    pulse(1, 12); pulse(2, 12); pulse(3, 12);

    setup(4, 2, "R5");
    pulse(1, 14); pulse(5, 14);

    setup(2, 3, "R6");
    pulse(3, 12); pulse(5, 12);

    // R7: settings changed during pulses and short gaps
    setup(5, 0, "R7");
    @(negedge clk); pwm_in = 1'b1; dly_code = 3'd1; edge_mode = 2'b10;
    idle_cycles(2);
    @(negedge clk); pwm_in = 1'b0; dly_code = 3'd7;
    idle_cycles(3);
    dly_code = 3'd2; edge_mode = 2'b01;
    pulse(4, 3);
    dly_code = 3'd6; edge_mode = 2'b00;
    pulse(3, 4); pulse(2, 16);
    pulse(3, 16);
    dly_code = 3'd0;
    pulse(2, 16);

    idle_cycles(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule